// File: doc/BRIEF.md
# Halting Watchdog Timer Peripheral

This block is a register-mapped watchdog for a small I/O bus that carries byte and halfword accesses inside a 32-byte window. A 10-bit down-counter steps once per slow tick. A prescaler divides the system clock down to make that tick, and in real use one tick lasts 0.6 s. Software loads a start value into an initial-value register. Any write to the reload register restarts the count from that value. A halt bit in the control register freezes counting. After reset the block starts halted, so nothing can expire before software has set it up.

Expiry happens in two stages. When the counter is at zero on a tick, the first expiry sets a timeout status bit, pulses the interrupt and restarts the count. If a second expiry follows with no reload in between, a second status bit is recorded and a one-cycle system-reset request is issued. The reboot-inhibit flag holds back that reset request, but the status bit is still recorded. Status bits are cleared by writing a one to them.

The request channel is valid/ready. Ready is held high, so a request is taken in every cycle that valid is high. A read returns its data one cycle later on `rsp_valid`/`rsp_data`, and that response has no back-pressure. Addresses are halfword indices, which are the byte offset divided by two. `bus_be` selects the low byte, the high byte or both.

Top module: `halt_wdog`

## Requirements
- R1: After reset: count = 4, control reads 0x0802 (halt bit 11 = 1, inhibit bit 1 = 1), initial value reads 0x0004, both status registers read 0, and `timeout_o`, `irq_o` and `rst_req_o` are low.
- R2: While running, a read of index 0 (byte offset 0x00) returns the count in bits [9:0] with the upper bits zero. The count falls by one every PRESCALE_DIV clocks, and the first step comes PRESCALE_DIV clocks after counting starts.
- R3: Control bit 11 (index 4, byte offset 0x08, high byte lane) is the halt bit. While it is 1 the count and the prescaler do not move. Readback returns the value in force.
- R4: Any write to index 0, whatever its data or lanes, loads the count from the initial-value field, restarts the prescaler and re-arms the first expiry stage. A write to the initial-value register does not change the count.
- R5: Index 9 (byte offset 0x12) holds the initial value in bits [9:0]. Bits [15:10] are stored per written byte lane and read back as written. If the merged bits [9:0] would be below 4, those bits keep their old value.
- R6: When the count is 0 on a tick and the block is armed, the block sets status bit 0 at index 2 (byte offset 0x04), which drives `timeout_o`. It also raises `irq_o` for exactly one cycle and reloads the count from the initial value.
- R7: A second expiry with no reload in between sets bit 0 at index 3 (byte offset 0x06) and reloads the count. If inhibit is clear, it also pulses `rst_req_o` for one cycle and sets bit 1 at index 3. The second expiry does not pulse `irq_o`, and the next expiry counts as a first one again.
- R8: With inhibit (control bit 1) set, a second expiry gives no `rst_req_o` pulse and leaves index 3 bit 1 clear, but index 3 bit 0 is still set.
- R9: Status bits are write-one-to-clear. A write of zero leaves them set, and a set event in the same cycle as a clear wins.
- R10: `bus_ready` is always 1. `rsp_valid` is high exactly in the cycle after each accepted read and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request ready, always 1 |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_hw_addr | input | 4 | Halfword index (byte offset / 2) |
| bus_be | input | 2 | Byte-lane enables, bit 0 = low byte |
| bus_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 16 | Read data |
| timeout_o | output | 1 | First-expiry status level |
| irq_o | output | 1 | One-cycle interrupt on first expiry |
| rst_req_o | output | 1 | One-cycle system-reset request |

## Verification
The counter is tried in three ways: held by the halt bit, running freely through both expiry stages with inhibit set, and running with a reload written between the two stages and inhibit clear. These three runs separate a stuck or free-running prescaler from a correct one, a missing re-arm from a correct one, and a reset request that ignores inhibit from one that respects it. The initial-value register gets full-width and single-lane writes, with values below and above the floor, so a rejection that wrongly drops the upper bits shows up. Status clearing is tried with both zero and one data.

// File: rtl/halt_wdog_pkg.sv
`timescale 1ns/1ps
package halt_wdog_pkg;
  localparam int unsigned DATA_W = 16;

  // halfword indices inside the 32-byte window
  localparam logic [3:0] IDX_COUNT = 4'h0;
  localparam logic [3:0] IDX_STS_A = 4'h2;
  localparam logic [3:0] IDX_STS_B = 4'h3;
  localparam logic [3:0] IDX_CTRL  = 4'h4;
  localparam logic [3:0] IDX_INIT  = 4'h9;

  localparam int unsigned HALT_BIT  = 11;
  localparam int unsigned INHIB_BIT = 1;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [3:0]        idx;
    logic [1:0]        be;
    logic [DATA_W-1:0] data;
  } wdog_req_t;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [1:0]        be
  );
    logic [DATA_W-1:0] r;
    r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
    r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
    return r;
  endfunction
endpackage

// File: rtl/halt_wdog_prescale.sv
`timescale 1ns/1ps
module halt_wdog_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          at_last;

  assign at_last = (pre_q == LAST);
  assign tick    = !hold && !restart && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)                 pre_q <= '0;
    else if (hold || restart)   pre_q <= '0;
    else if (at_last)           pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/halt_wdog_count.sv
`timescale 1ns/1ps
module halt_wdog_count #(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned INIT_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic             inhib,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] count,
  output logic             first_exp,
  output logic             second_exp,
  output logic             irq,
  output logic             rst_req
);
  logic [CNT_W-1:0] count_q;
  logic             armed_q;
  logic             expire;

  assign expire     = tick && (count_q == '0);
  assign first_exp  = expire && !armed_q;
  assign second_exp = expire && armed_q;
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= CNT_W'(INIT_RESET);
      armed_q <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      irq     <= first_exp;
      rst_req <= second_exp && !inhib;
      if (reload) begin
        count_q <= init_val;
        armed_q <= 1'b0;
      end else if (expire) begin
        count_q <= init_val;
        armed_q <= !armed_q;
      end else if (tick) begin
        count_q <= count_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/halt_wdog_regs.sv
`timescale 1ns/1ps
module halt_wdog_regs
  import halt_wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned INIT_RESET = 4,
  parameter int unsigned INIT_MIN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wdog_req_t         req,
  input  logic [CNT_W-1:0]  count,
  input  logic              set_tmo,
  input  logic              set_sec,
  input  logic              set_boot,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              reload,
  output logic              halt,
  output logic              inhib,
  output logic [CNT_W-1:0]  init_val,
  output logic              timeout
);
  logic [DATA_W-1:0] init_q;
  logic [DATA_W-1:0] init_merged;
  logic              halt_q, inhib_q;
  logic              tmo_q, sec_q, boot_q;
  logic              wr_init, wr_ctrl, clr_a0, clr_b0, clr_b1;
  logic [DATA_W-1:0] rdata;

  assign init_merged = lane_merge(init_q, req.data, req.be);
  assign wr_init = req.wr && (req.idx == IDX_INIT);
  assign wr_ctrl = req.wr && (req.idx == IDX_CTRL);
  assign clr_a0  = req.wr && (req.idx == IDX_STS_A) && req.be[0] && req.data[0];
  assign clr_b0  = req.wr && (req.idx == IDX_STS_B) && req.be[0] && req.data[0];
  assign clr_b1  = req.wr && (req.idx == IDX_STS_B) && req.be[0] && req.data[1];

  assign reload   = req.wr && (req.idx == IDX_COUNT);
  assign halt     = halt_q;
  assign inhib    = inhib_q;
  assign init_val = init_q[CNT_W-1:0];
  assign timeout  = tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= DATA_W'(INIT_RESET);
      halt_q  <= 1'b1;
      inhib_q <= 1'b1;
    end else begin
      if (wr_init) begin
        init_q[DATA_W-1:CNT_W] <= init_merged[DATA_W-1:CNT_W];
        if (init_merged[CNT_W-1:0] >= CNT_W'(INIT_MIN))
          init_q[CNT_W-1:0] <= init_merged[CNT_W-1:0];
      end
      if (wr_ctrl && req.be[1]) halt_q  <= req.data[HALT_BIT];
      if (wr_ctrl && req.be[0]) inhib_q <= req.data[INHIB_BIT];
    end
  end

  // status: a set in the same cycle overrides a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q  <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      tmo_q  <= set_tmo  || (tmo_q  && !clr_a0);
      sec_q  <= set_sec  || (sec_q  && !clr_b0);
      boot_q <= set_boot || (boot_q && !clr_b1);
    end
  end

  always_comb begin
    rdata = '0;
    unique case (req.idx)
      IDX_COUNT: rdata = DATA_W'(count);
      IDX_STS_A: rdata = {15'b0, tmo_q};
      IDX_STS_B: rdata = {14'b0, boot_q, sec_q};
      IDX_CTRL: begin
        rdata[HALT_BIT]  = halt_q;
        rdata[INHIB_BIT] = inhib_q;
      end
      IDX_INIT:  rdata = init_q;
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req.rd;
      if (req.rd) rsp_data <= rdata;
    end
  end
endmodule

// File: rtl/halt_wdog.sv
`timescale 1ns/1ps
module halt_wdog
  import halt_wdog_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 60_000_000,
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned INIT_RESET   = 4,
  parameter int unsigned INIT_MIN     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  output logic        bus_ready,
  input  logic        bus_write,
  input  logic [3:0]  bus_hw_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic        timeout_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  wdog_req_t        req;
  logic             tick_w, reload_w, halt_w, inhib_w;
  logic [CNT_W-1:0] count_w, init_w;
  logic             first_w, second_w;

  assign bus_ready = 1'b1;
  assign req.wr   = bus_valid && bus_ready && bus_write;
  assign req.rd   = bus_valid && bus_ready && !bus_write;
  assign req.idx  = bus_hw_addr;
  assign req.be   = bus_be;
  assign req.data = bus_wdata;

  halt_wdog_prescale #(.DIV(PRESCALE_DIV)) pre_i (
    .clk(clk), .rst_n(rst_n), .hold(halt_w), .restart(reload_w), .tick(tick_w)
  );

  halt_wdog_count #(.CNT_W(CNT_W), .INIT_RESET(INIT_RESET)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .reload(reload_w), .inhib(inhib_w),
    .init_val(init_w), .count(count_w), .first_exp(first_w),
    .second_exp(second_w), .irq(irq_o), .rst_req(rst_req_o)
  );

  halt_wdog_regs #(.CNT_W(CNT_W), .INIT_RESET(INIT_RESET), .INIT_MIN(INIT_MIN)) reg_i (
    .clk(clk), .rst_n(rst_n), .req(req), .count(count_w),
    .set_tmo(first_w), .set_sec(second_w), .set_boot(second_w && !inhib_w),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .reload(reload_w),
    .halt(halt_w), .inhib(inhib_w), .init_val(init_w), .timeout(timeout_o)
  );
endmodule

// File: rtl/halt_wdog_chk.sv
`timescale 1ns/1ps
module halt_wdog_chk #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned INIT_MIN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             rsp_valid,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             timeout_o,
  input logic             halt_w,
  input logic             inhib_w,
  input logic             reload_w,
  input logic [CNT_W-1:0] count_w,
  input logic [CNT_W-1:0] init_w
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R6
  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> timeout_o); // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R7
  AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !$past(inhib_w)); // R8
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt_w) && !$past(reload_w)) |-> (count_w == $past(count_w))); // R3
  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    init_w >= CNT_W'(INIT_MIN)); // R5
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !bus_write)); // R10
endmodule

bind halt_wdog halt_wdog_chk #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .rsp_valid(rsp_valid), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .timeout_o(timeout_o), .halt_w(halt_w), .inhib_w(inhib_w),
  .reload_w(reload_w), .count_w(count_w), .init_w(init_w)
);

// File: tb/halt_wdog_tb_top.sv
`timescale 1ns/1ps
module halt_wdog_tb_top;
  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic        bus_ready;
  logic [3:0]  bus_hw_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        timeout_o, irq_o, rst_req_o;

  int n_vec = 0, n_bad = 0, irq_cnt = 0, rst_cnt = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  halt_wdog #(.PRESCALE_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_hw_addr(bus_hw_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .timeout_o(timeout_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as responses appear, counts pulses
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 16'h1, 16'h0);
      else chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
    if (irq_o)     irq_cnt++;
    if (rst_req_o) rst_cnt++;
  end

  task automatic wr(input logic [3:0] idx, input logic [1:0] be, input logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_hw_addr = idx; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_hw_addr = idx; bus_be = 2'b11;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R10 watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 timeout low", {15'b0, timeout_o}, 16'h0);
    chk("R1 irq low", {15'b0, irq_o}, 16'h0);
    chk("R1 rst_req low", {15'b0, rst_req_o}, 16'h0);
    chk("R10 ready high", {15'b0, bus_ready}, 16'h1);
    rd(4'h0, 16'h0004, "R1 count");
    rd(4'h4, 16'h0802, "R1 control");
    rd(4'h9, 16'h0004, "R1 init");
    rd(4'h2, 16'h0000, "R1 status a");
    rd(4'h3, 16'h0000, "R1 status b");
    repeat (40) @(negedge clk);
    rd(4'h0, 16'h0004, "R3 halted count");

    wr(4'h9, 2'b11, 16'h0002); rd(4'h9, 16'h0004, "R5 reject 2");
    wr(4'h9, 2'b11, 16'hFC10); rd(4'h9, 16'hFC10, "R5 full write");
    wr(4'h9, 2'b11, 16'h0403); rd(4'h9, 16'h0410, "R5 upper kept, low rejected");
    wr(4'h9, 2'b01, 16'h0020); rd(4'h9, 16'h0420, "R5 low lane");
    wr(4'h9, 2'b11, 16'h0008); rd(4'h9, 16'h0008, "R5 set 8");
    rd(4'h0, 16'h0004, "R4 init write leaves count");
    wr(4'h0, 2'b11, 16'hFFFF); rd(4'h0, 16'h0008, "R4 reload");

    // run, inhibit kept set (high lane only)
    wr(4'h4, 2'b10, 16'h0000);
    rd(4'h0, 16'h0008, "R3 no step yet");
    repeat (8) @(negedge clk);
    rd(4'h0, 16'h0006, "R2 two steps");
    repeat (34) @(negedge clk);
    chk("R6 irq pulses", 16'(irq_cnt), 16'd1);
    chk("R6 timeout level", {15'b0, timeout_o}, 16'h1);
    rd(4'h2, 16'h0001, "R6 status a");
    rd(4'h0, 16'h0006, "R6 reloaded then stepping");
    repeat (30) @(negedge clk);
    chk("R8 no reset request", 16'(rst_cnt), 16'd0);
    chk("R7 no irq on second", 16'(irq_cnt), 16'd1);
    rd(4'h3, 16'h0001, "R8 second recorded, boot clear");
    wr(4'h4, 2'b11, 16'h0802);
    rd(4'h4, 16'h0802, "R3 control readback");

    wr(4'h2, 2'b11, 16'h0000); rd(4'h2, 16'h0001, "R9 zero write keeps");
    wr(4'h3, 2'b11, 16'h0001); rd(4'h3, 16'h0000, "R9 clear b");
    wr(4'h2, 2'b11, 16'h0001); rd(4'h2, 16'h0000, "R9 clear a");
    chk("R9 timeout cleared", {15'b0, timeout_o}, 16'h0);

    // run with inhibit clear, reload between stages
    wr(4'h0, 2'b11, 16'h0000);
    wr(4'h4, 2'b11, 16'h0000);
    repeat (40) @(negedge clk);
    chk("R6 second first-expiry", 16'(irq_cnt), 16'd2);
    wr(4'h0, 2'b01, 16'h0000);
    rd(4'h0, 16'h0008, "R4 byte reload");
    repeat (42) @(negedge clk);
    chk("R4 re-armed irq", 16'(irq_cnt), 16'd3);
    chk("R4 no reset after reload", 16'(rst_cnt), 16'd0);
    repeat (35) @(negedge clk);
    chk("R7 reset request", 16'(rst_cnt), 16'd1);
    chk("R7 irq unchanged", 16'(irq_cnt), 16'd3);
    rd(4'h3, 16'h0003, "R7 status b");
    wr(4'h4, 2'b11, 16'h0802);

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 16'(exp_q.size()), 16'd0);
    summary();
    $finish;
  end
endmodule